// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command bus of a four-bank synchronous DRAM for two tasks. First it runs the power-up sequence. While reset is applied, clock enable is held low and chip select is held high. After reset, clock enable goes high and only NOP appears on the bus for a programmable settling pause. Two AUTO REFRESH commands follow, a tRC apart. Then a LOAD MODE REGISTER command writes a burst length of 1, 2 or 4, interleaved ordering and the CAS latency. After tMRD the ready flag rises and stays high.

From then on the block keeps the memory refreshed. An interval timer adds one owed refresh every `REF_INTERVAL_CYC` clocks, which is 15.6 µs in the default setting. A saturating counter tracks how many refreshes are owed, and a request line stays high while any are owed. When the memory controller grants the bus, the block issues PRECHARGE ALL, waits tRP, and issues AUTO REFRESH. It repeats this service while the grant and the owed count both remain.

If a refresh interval ends while the counter is already full, the refresh budget has been exceeded. The next service then issues two AUTO REFRESH commands back to back, spaced by tRC, in the same way as the power-up wake-up. All delays are whole clock counts given as parameters.

Top module: `sdram_init_refresh`

## Requirements
- R1: While reset is applied, CKE is 0 and CS# is 1. From the first clock after reset CKE is 1, and the bus carries only NOP until the first command, which appears exactly `PAUSE_CYC` clocks after reset release.
- R2: The first command is AUTO REFRESH. A second AUTO REFRESH follows `T_RC_CYC` clocks later. LOAD MODE REGISTER follows `T_RC_CYC` clocks after the second refresh.
- R3: During LOAD MODE REGISTER, BA is 0 and the address carries the mode word: A[2:0] holds the burst-length code (1→0, 2→1, 4→2), A3 is 1 (interleaved ordering), A[6:4] holds the CAS latency, and all other bits are 0.
- R4: `ready` is 0 until `T_MRD_CYC` clocks after LOAD MODE REGISTER. It is 1 from then on. Only NOP appears in the clock right after LOAD MODE REGISTER.
- R5: Once `ready` is 1, one owed refresh is added every `REF_INTERVAL_CYC` clocks. The first one is added `REF_INTERVAL_CYC` clocks after `ready` rises. `ref_req` is 1 exactly while the owed count is non-zero, and it is 0 before `ready`.
- R6: When `ref_gnt` and `ref_req` are both 1 while the block is idle, PRECHARGE ALL (A10 = 1) appears on the next clock. AUTO REFRESH follows `T_RP_CYC` clocks later. The owed count drops by one in the clock where that AUTO REFRESH appears.
- R7: No command follows an AUTO REFRESH sooner than `T_RC_CYC` clocks. While the grant is held and refreshes are still owed, each following PRECHARGE ALL comes `T_RC_CYC + 1` clocks after the previous AUTO REFRESH.
- R8: The owed count saturates at `PEND_MAX`. An interval that ends at full count marks the refresh budget as exceeded. The next service then issues a second AUTO REFRESH `T_RC_CYC` clocks after the first, with no PRECHARGE ALL between them. The mark is cleared once that second refresh is issued.
- R9: Commands are encoded on {CS#, RAS#, CAS#, WE#} as follows: NOP 0111, LOAD MODE REGISTER 0000, AUTO REFRESH 0001, PRECHARGE 0010.
- R10: A grant that arrives while nothing is owed issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_gnt | input | 1 | Controller hands the command bus to the sequencer |
| ref_req | output | 1 | One or more refreshes are owed |
| ready | output | 1 | Power-up sequence finished; sticky |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (mode word, A10 for precharge all) |
| sd_ba | output | BA_W | Bank address, always 0 |

## Verification
The bench records every command with its clock number and compares the sequence against a table of exact cycles. This exposes an off-by-one in any wait counter: an early or late refresh, mode load or precharge moves a time stamp. A grant is held across several intervals, so a design that double-refreshed without cause, or that served a grant with nothing owed, would insert extra entries. The grant is then withheld until the owed count saturates and one more interval expires. A design that failed to detect the exceeded budget would skip the second back-to-back refresh. A design that let the counter wrap would drop the request. The edges of the ready flag and of the request are sampled on the exact clocks where they must change.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Command code on {CS#, RAS#, CAS#, WE#}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_AR  = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_AR2,
        ST_LMR,
        ST_MRD,
        ST_IDLE,
        ST_REF,
        ST_RC
    } seq_state_e;

    // Mode word: burst-length code, interleaved bit, CAS latency
    function automatic logic [15:0] mode_word(input int bl, input int cl);
        logic [2:0] blc;
        logic [2:0] clc;
        blc = (bl == 4) ? 3'd2 : ((bl == 2) ? 3'd1 : 3'd0);
        clc = cl[2:0];
        return {9'd0, clc, 1'b1, blc};
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
    parameter int REF_INTERVAL_CYC = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(REF_INTERVAL_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(REF_INTERVAL_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sdram_ref_pending.sv
module sdram_ref_pending #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic served,
    input  logic clr_overdue,
    output logic owed,
    output logic overdue
);
    localparam int CW = $clog2(PEND_MAX + 1);
    localparam logic [CW-1:0] MAXV = CW'(PEND_MAX);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovd;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_overdue) pend_d.ovd = 1'b0;
        if (tick && !served) begin
            if (pend_q.cnt == MAXV) pend_d.ovd = 1'b1;
            else                    pend_d.cnt = pend_q.cnt + 1'b1;
        end else if (!tick && served && (pend_q.cnt != '0)) begin
            pend_d.cnt = pend_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign owed    = (pend_q.cnt != '0);
    assign overdue = pend_q.ovd;
endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sdr_cmd_e          cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BA_W-1:0]   ba_o
);
    typedef struct packed {
        logic [3:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [BA_W-1:0]   ba;
        logic              cke;
    } drive_t;

    drive_t drv_d, drv_q;

    always_comb begin
        drv_d.cmd  = cmd_i;
        drv_d.addr = addr_i;
        drv_d.ba   = '0;
        drv_d.cke  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q.cmd  <= CMD_INH;
            drv_q.addr <= '0;
            drv_q.ba   <= '0;
            drv_q.cke  <= 1'b0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = drv_q.cmd;
    assign addr_o = drv_q.addr;
    assign ba_o   = drv_q.ba;
    assign cke_o  = drv_q.cke;
endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W           = 12,
    parameter int BA_W             = 2,
    parameter int PAUSE_CYC        = 12500,
    parameter int REF_INTERVAL_CYC = 1950,
    parameter int T_RC_CYC         = 8,
    parameter int T_RP_CYC         = 3,
    parameter int T_MRD_CYC        = 2,
    parameter int PEND_MAX         = 8,
    parameter int BURST_LEN        = 4,
    parameter int CAS_LAT          = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_gnt,
    output logic              ref_req,
    output logic              ready,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba
);
    localparam int WMAX   = max_of(max_of(PAUSE_CYC, T_RC_CYC), max_of(T_RP_CYC, T_MRD_CYC));
    localparam int WAIT_W = $clog2(WMAX + 1);
    localparam logic [WAIT_W-1:0] PAUSE_M1 = WAIT_W'(PAUSE_CYC - 1);
    localparam logic [WAIT_W-1:0] TRC_M1   = WAIT_W'(T_RC_CYC - 1);
    localparam logic [WAIT_W-1:0] TRP_M1   = WAIT_W'(T_RP_CYC - 1);
    localparam logic [WAIT_W-1:0] TMRD_M1  = WAIT_W'(T_MRD_CYC - 1);
    localparam logic [15:0]       MODE_FULL = mode_word(BURST_LEN, CAS_LAT);
    localparam logic [ADDR_W-1:0] MODE_ADDR = MODE_FULL[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << 10;

    typedef struct packed {
        seq_state_e        state;
        logic [WAIT_W-1:0] wait_cnt;
        logic              ready;
    } seq_t;

    seq_t              seq_d, seq_q;
    sdr_cmd_e          cmd_nxt;
    logic [ADDR_W-1:0] addr_nxt;
    logic              served, clr_ovd, tick, owed, overdue;

    always_comb begin
        seq_d    = seq_q;
        cmd_nxt  = CMD_NOP;
        addr_nxt = '0;
        served   = 1'b0;
        clr_ovd  = 1'b0;
        if (seq_q.wait_cnt != '0) begin
            seq_d.wait_cnt = seq_q.wait_cnt - 1'b1;
        end else begin
            unique case (seq_q.state)
                ST_PAUSE: begin
                    cmd_nxt        = CMD_AR;
                    seq_d.wait_cnt = TRC_M1;
                    seq_d.state    = ST_AR2;
                end
                ST_AR2: begin
                    cmd_nxt        = CMD_AR;
                    seq_d.wait_cnt = TRC_M1;
                    seq_d.state    = ST_LMR;
                end
                ST_LMR: begin
                    cmd_nxt        = CMD_LMR;
                    addr_nxt       = MODE_ADDR;
                    seq_d.wait_cnt = TMRD_M1;
                    seq_d.state    = ST_MRD;
                end
                ST_MRD: begin
                    seq_d.ready = 1'b1;
                    seq_d.state = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_gnt && owed) begin
                        cmd_nxt        = CMD_PRE;
                        addr_nxt       = PALL_ADDR;
                        seq_d.wait_cnt = TRP_M1;
                        seq_d.state    = ST_REF;
                    end
                end
                ST_REF: begin
                    cmd_nxt        = CMD_AR;
                    served         = 1'b1;
                    seq_d.wait_cnt = TRC_M1;
                    seq_d.state    = ST_RC;
                end
                ST_RC: begin
                    if (overdue) begin
                        cmd_nxt        = CMD_AR;
                        served         = 1'b1;
                        clr_ovd        = 1'b1;
                        seq_d.wait_cnt = TRC_M1;
                    end else begin
                        seq_d.state = ST_IDLE;
                    end
                end
                default: seq_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state    <= ST_PAUSE;
            seq_q.wait_cnt <= PAUSE_M1;
            seq_q.ready    <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    sdram_ref_timer #(
        .REF_INTERVAL_CYC(REF_INTERVAL_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (seq_q.ready),
        .tick (tick)
    );

    sdram_ref_pending #(
        .PEND_MAX(PEND_MAX)
    ) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .served     (served),
        .clr_overdue(clr_ovd),
        .owed       (owed),
        .overdue    (overdue)
    );

    sdram_cmd_reg #(
        .ADDR_W(ADDR_W),
        .BA_W  (BA_W)
    ) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_nxt),
        .addr_i (addr_nxt),
        .cke_o  (sd_cke),
        .cs_n_o (sd_cs_n),
        .ras_n_o(sd_ras_n),
        .cas_n_o(sd_cas_n),
        .we_n_o (sd_we_n),
        .addr_o (sd_addr),
        .ba_o   (sd_ba)
    );

    assign ready   = seq_q.ready;
    assign ref_req = owed;
endmodule

// File: rtl/sdram_seq_checker.sv
module sdram_seq_checker
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 2,
    parameter int T_RC_CYC  = 8,
    parameter int T_RP_CYC  = 3,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_req,
    input logic              ready,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BA_W-1:0]   sd_ba
);
    localparam int GW = $clog2(T_RC_CYC + T_RP_CYC + 2) + 1;
    localparam logic [GW-1:0] RC_V = GW'(T_RC_CYC);
    localparam logic [GW-1:0] RP_V = GW'(T_RP_CYC);
    localparam logic [15:0]   MODE_FULL = mode_word(BURST_LEN, CAS_LAT);

    logic [3:0] cmd;
    logic is_ar, is_pre, is_lmr;
    logic [GW-1:0] ar_gap_q, pre_gap_q;
    logic lmr_seen_q;

    assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_ar  = (cmd == 4'b0001);
    assign is_pre = (cmd == 4'b0010);
    assign is_lmr = (cmd == 4'b0000);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_gap_q   <= '0;
            pre_gap_q  <= '0;
            lmr_seen_q <= 1'b0;
        end else begin
            if (is_ar)                                 ar_gap_q <= GW'(1);
            else if (ar_gap_q != '0 && ar_gap_q < RC_V) ar_gap_q <= ar_gap_q + 1'b1;
            if (is_pre)                                  pre_gap_q <= GW'(1);
            else if (pre_gap_q != '0 && pre_gap_q < RP_V) pre_gap_q <= pre_gap_q + 1'b1;
            if (is_lmr) lmr_seen_q <= 1'b1;
        end
    end

    AST_CKE_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cs_n |-> sd_cke); // R1
    AST_MODE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        is_lmr |-> (sd_addr == MODE_FULL[ADDR_W-1:0] && sd_ba == '0)); // R3
    AST_MRD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        is_lmr |=> (cmd == 4'b0111)); // R4
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R4
    AST_READY_AFTER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !lmr_seen_q |-> !ready); // R4
    AST_NO_REQ_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !ref_req); // R5
    AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_addr[10]); // R6
    AST_PRE_TO_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ar && ready && pre_gap_q != '0) |-> (pre_gap_q == RP_V)); // R6
    AST_RC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ar || is_pre || is_lmr) |-> (ar_gap_q == '0 || ar_gap_q >= RC_V)); // R7
endmodule

bind sdram_init_refresh sdram_seq_checker #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .T_RC_CYC (T_RC_CYC),
    .T_RP_CYC (T_RP_CYC),
    .BURST_LEN(BURST_LEN),
    .CAS_LAT  (CAS_LAT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_req (ref_req),
    .ready   (ready),
    .sd_cke  (sd_cke),
    .sd_cs_n (sd_cs_n),
    .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n),
    .sd_we_n (sd_we_n),
    .sd_addr (sd_addr),
    .sd_ba   (sd_ba)
);

// File: tb/sdram_init_refresh_bench.sv
module sdram_init_refresh_bench;
    localparam int ADDR_W = 12;
    localparam int BA_W   = 2;
    localparam int NEXP   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_gnt = 1'b0;
    logic ref_req, ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [BA_W-1:0]   sd_ba;

    always #4 clk = ~clk;

    sdram_init_refresh #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .PAUSE_CYC(20), .REF_INTERVAL_CYC(40),
        .T_RC_CYC(4), .T_RP_CYC(2), .T_MRD_CYC(2), .PEND_MAX(8),
        .BURST_LEN(4), .CAS_LAT(3)
    ) u_sdram_init_refresh (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .ready(ready),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
    );

    // Expected command log: R9 codes AR=0001 LMR=0000 PRE=0010, cycle after reset release, address
    localparam logic [3:0] EXP_CMD [NEXP] = '{
        4'b0001, 4'b0001, 4'b0000, 4'b0010, 4'b0001, 4'b0010, 4'b0001, 4'b0010, 4'b0001, 4'b0010,
        4'b0001, 4'b0010, 4'b0001, 4'b0001, 4'b0010, 4'b0001, 4'b0010, 4'b0001, 4'b0010, 4'b0001};
    localparam int EXP_CYC [NEXP] = '{
        20, 24, 28, 81, 83, 111, 113, 151, 153, 191,
        193, 561, 563, 567, 572, 574, 579, 581, 586, 588};
    localparam logic [ADDR_W-1:0] EXP_ADDR [NEXP] = '{
        12'h000, 12'h000, 12'h03A, 12'h400, 12'h000, 12'h400, 12'h000, 12'h400, 12'h000, 12'h400,
        12'h000, 12'h400, 12'h000, 12'h000, 12'h400, 12'h000, 12'h400, 12'h000, 12'h400, 12'h000};

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [3:0]        rec_cmd  [64];
    int                rec_cyc  [64];
    logic [ADDR_W-1:0] rec_addr [64];
    int                rec_n = 0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst_n && !sd_cs_n && ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111) && rec_n < 64) begin
            rec_cmd[rec_n]  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            rec_cyc[rec_n]  = cyc;
            rec_addr[rec_n] = sd_addr;
            rec_n = rec_n + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        while (cyc != n) @(negedge clk);
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R1 R2 first refresh after pause";
            1:       return "R2 second wake-up refresh";
            2:       return "R3 mode load word";
            3, 4:    return "R6 R9 precharge-all then refresh";
            5, 6:    return "R5 R10 next interval service";
            7, 8:    return "R5 R10 interval service";
            9, 10:   return "R5 R10 interval service";
            11, 12:  return "R8 service after saturation";
            13:      return "R8 extra back-to-back refresh";
            default: return "R7 catch-up spacing";
        endcase
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sd_cke == 1'b0, "R1 cke in reset", longint'(sd_cke), 0);
        check(sd_cs_n == 1'b1, "R1 cs_n in reset", longint'(sd_cs_n), 1);
        check(ready == 1'b0, "R4 ready in reset", longint'(ready), 0);
        check(ref_req == 1'b0, "R5 req in reset", longint'(ref_req), 0);
        rst_n = 1'b1;
        wait_cyc(1);
        check(sd_cke == 1'b1, "R1 cke after reset", longint'(sd_cke), 1);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP during pause",
              longint'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        wait_cyc(29);
        check(ready == 1'b0, "R4 ready before tMRD", longint'(ready), 0);
        wait_cyc(30);
        check(ready == 1'b1, "R4 ready after tMRD", longint'(ready), 1);
        wait_cyc(69);
        check(ref_req == 1'b0, "R5 req before interval", longint'(ref_req), 0);
        wait_cyc(70);
        check(ref_req == 1'b1, "R5 req at interval", longint'(ref_req), 1);
        wait_cyc(80);
        ref_gnt = 1'b1;
        wait_cyc(82);
        check(ref_req == 1'b1, "R6 req held until refresh", longint'(ref_req), 1);
        wait_cyc(83);
        check(ref_req == 1'b0, "R6 req drops with refresh", longint'(ref_req), 0);
        wait_cyc(200);
        ref_gnt = 1'b0;
        wait_cyc(550);
        check(ref_req == 1'b1, "R8 req held at saturation", longint'(ref_req), 1);
        wait_cyc(560);
        ref_gnt = 1'b1;
        wait_cyc(600);
        check(ready == 1'b1, "R4 ready sticky", longint'(ready), 1);
        check(rec_n >= NEXP, "R7 command count", longint'(rec_n), NEXP);
        for (int i = 0; i < NEXP; i++) begin
            check(rec_cmd[i] == EXP_CMD[i] && rec_cyc[i] == EXP_CYC[i] && rec_addr[i] == EXP_ADDR[i],
                  tag_of(i),
                  {longint'(rec_cyc[i]), rec_cmd[i], rec_addr[i]},
                  {longint'(EXP_CYC[i]), EXP_CMD[i], EXP_ADDR[i]});
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule